// File: doc/BRIEF.md
# Per-Pixel Gain/Offset Correction Pipeline with Double-Buffered Coefficients

This block corrects a raw focal-plane video stream one pixel per clock. Every pixel carries a position in raster order. The block reads a gain and an offset stored for that exact position, multiplies the pixel by the gain and adds the offset. The result is clamped to the 14-bit pixel range and leaves a fixed three-stage pipeline together with its frame and line markers. Both the pixel input and the corrected output use valid/ready handshakes. A stall at the output freezes the whole pipeline.

The coefficients sit in two on-chip banks. One bank, the active bank, serves video. A slow loader stream fills the other bank. Software or a temperature supervisor picks a stored coefficient set, for example by focal-plane temperature. It then pulses a start input with an identifier for that set and streams COLS*ROWS words. The new set goes live in one step on the first pixel of the next frame, and only once every word has arrived. A frame that begins while the load is unfinished still uses the old set.

The loader is a three-state machine. In `LD_IDLE` no load is pending. Transition `T_START` (a start pulse) leads to `LD_FILL`, where words are accepted into the inactive bank. Transition `T_FULL` (the last word accepted) leads to `LD_ARMED`, which waits for a frame start. Transition `T_SWAP` (an accepted start-of-frame pixel) swaps the banks and returns to `LD_IDLE`.

Top module: `pixel_nuc`

## Requirements
- R1: Each output pixel equals clamp(((pixel * gain) >> 12) + offset) into the range 0..16383. The pixel is 14-bit unsigned, the gain is 16-bit unsigned with 12 fraction bits (4096 means 1.0), and the offset is 16-bit two's complement.
- R2: The coefficient index is 0 for a pixel accepted with `pix_sof` high and increases by one for each further accepted pixel. The index row*COLS+col therefore follows raster order. A new `pix_sof` restarts the index at 0 even when the previous frame ended early.
- R3: A pixel accepted at a clock edge appears on `out_data` three edges later when no stall occurs. `out_sof` and `out_eol` come out on the same cycle as the pixel they marked.
- R4: While `out_ready` stays high, `pix_ready` stays high, so one pixel per clock is accepted.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `pix_ready` is low.
- R6: A `ld_start` pulse in `LD_IDLE` captures `ld_set` and raises `swap_pending`. After that, `ld_ready` is high until exactly COLS*ROWS words have been accepted. The words fill indices 0, 1, 2 … of the bank that is not active.
- R7: In `LD_ARMED`, the first accepted pixel with `pix_sof` high toggles `active_bank`, loads the captured identifier into `active_set` and clears `swap_pending`. That pixel and the rest of its frame already use the new coefficients.
- R8: An accepted start-of-frame pixel in `LD_FILL` leaves the active bank, `active_set` and the coefficients unchanged, and `swap_pending` stays high. Partial loader writes never alter the coefficients in use.
- R9: A `ld_start` pulse outside `LD_IDLE` has no effect: it neither restarts the word count nor replaces the captured identifier.
- R10: After reset, `out_valid`, `swap_pending`, `ld_ready`, `active_bank` and `active_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_data | input | 14 | Raw pixel value |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_eol | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Corrected pixel valid |
| out_ready | input | 1 | Downstream accepts the corrected pixel |
| out_data | output | 14 | Corrected pixel |
| out_sof | output | 1 | Delayed frame-start marker |
| out_eol | output | 1 | Delayed end-of-line marker |
| ld_start | input | 1 | Request to load a new coefficient set |
| ld_set | input | SET_W | Identifier of the set being loaded |
| ld_valid | input | 1 | Loader word valid |
| ld_ready | output | 1 | Loader word accepted when valid |
| ld_gain | input | 16 | Gain word, unsigned 4.12 |
| ld_offset | input | 16 | Offset word, signed |
| active_bank | output | 1 | Index of the bank serving video |
| active_set | output | SET_W | Identifier of the set in use |
| swap_pending | output | 1 | A load has been requested and not yet swapped in |

## Verification
The hardest state to reach is a frame boundary that falls while a load is only half written, followed by a second start request in the same window. The bench stops the loader stream midway and runs a whole frame, which must still match the old coefficient table. It then pulses the start input again and streams only the remaining words, expecting `ld_ready` to fall right after them. Output back-pressure is produced by a fixed pattern on `out_ready` during one frame, so stalls land on every pipeline stage.

// File: rtl/pixel_nuc_pkg.sv
package pixel_nuc_pkg;

    localparam int PIX_W   = 14;
    localparam int GAIN_W  = 16;
    localparam int FRAC_W  = 12;
    localparam int OFS_W   = 16;
    localparam int NUM_BANKS = 2;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [OFS_W-1:0]  ofs;
    } coeff_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FILL  = 2'd1,
        LD_ARMED = 2'd2
    } ld_state_e;

endpackage

// File: rtl/pixel_nuc_bank.sv
module pixel_nuc_bank
    import pixel_nuc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  coeff_t        wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output coeff_t        rdata
);

    coeff_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/pixel_nuc_loader.sv
module pixel_nuc_loader
    import pixel_nuc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int SET_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SET_W-1:0] set_id,
    input  logic             word_valid,
    input  logic             frame_go,
    output logic             word_ready,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic             wr_bank,
    output logic             swap_now,
    output logic             active_bank,
    output logic [SET_W-1:0] active_set,
    output logic             pending
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    ld_state_e        state_q;
    ld_state_e        state_d;
    logic [AW-1:0]    cnt_q;
    logic [SET_W-1:0] staged_q;
    logic             active_q;
    logic [SET_W-1:0] active_set_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_START, T_FULL, T_SWAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: begin
                if (start) begin
                    state_d = LD_FILL;
                end
            end
            LD_FILL: begin
                if (word_valid && cnt_q == LAST_IDX) begin
                    state_d = LD_ARMED;
                end
            end
            LD_ARMED: begin
                if (frame_go) begin
                    state_d = LD_IDLE;
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        word_ready = 1'b0;
        swap_now   = 1'b0;
        pending    = 1'b1;
        unique case (state_q)
            LD_IDLE:  pending    = 1'b0;
            LD_FILL:  word_ready = 1'b1;
            LD_ARMED: swap_now   = frame_go;
            default:  pending    = 1'b0;
        endcase
    end

    assign we          = word_ready && word_valid;
    assign waddr       = cnt_q;
    assign wr_bank     = ~active_q;
    assign active_bank = active_q;
    assign active_set  = active_set_q;

    // Counter, captured identifier and bank pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            staged_q     <= '0;
            active_q     <= 1'b0;
            active_set_q <= '0;
        end else begin
            if (state_q == LD_IDLE && start) begin
                cnt_q    <= '0;
                staged_q <= set_id;
            end else if (we) begin
                cnt_q <= cnt_q + AW'(1);
            end
            if (swap_now) begin
                active_q     <= ~active_q;
                active_set_q <= staged_q;
            end
        end
    end

endmodule

// File: rtl/pixel_nuc_math.sv
module pixel_nuc_math
    import pixel_nuc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sof,
    input  logic             in_eol,
    input  coeff_t           s1_coeff,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_sof,
    output logic             out_eol
);

    localparam int PROD_W = PIX_W + GAIN_W;
    localparam int SH_W   = PROD_W - FRAC_W;
    localparam int WIDE_W = (SH_W > OFS_W) ? SH_W : OFS_W;
    localparam int SUM_W  = WIDE_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << PIX_W) - 1);

    // Stage 1 (pixel side, coefficient arrives from bank register)
    logic             v1, v2, v3;
    logic             sof1, sof2, sof3;
    logic             eol1, eol2, eol3;
    logic [PIX_W-1:0] pix1;
    // Stage 2
    logic [SH_W-1:0]  sh2;
    logic [OFS_W-1:0] ofs2;
    // Stage 3
    logic [PIX_W-1:0] res3;

    logic [PROD_W-1:0]       prod_c;
    logic [SH_W-1:0]         sh_c;
    logic signed [SUM_W-1:0] sum_c;
    logic [PIX_W-1:0]        clamp_c;

    always_comb begin
        prod_c = PROD_W'(pix1) * PROD_W'(s1_coeff.gain);
        sh_c   = SH_W'(prod_c >> FRAC_W);
    end

    always_comb begin
        sum_c = $signed({{(SUM_W - SH_W){1'b0}}, sh2})
              + $signed({{(SUM_W - OFS_W){ofs2[OFS_W-1]}}, ofs2});
        if (sum_c < 0) begin
            clamp_c = '0;
        end else if (sum_c > SAT_HI) begin
            clamp_c = '1;
        end else begin
            clamp_c = sum_c[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {v1, v2, v3}       <= '0;
            {sof1, sof2, sof3} <= '0;
            {eol1, eol2, eol3} <= '0;
        end else if (adv) begin
            v1   <= in_valid;
            v2   <= v1;
            v3   <= v2;
            sof1 <= in_sof && in_valid;
            sof2 <= sof1;
            sof3 <= sof2;
            eol1 <= in_eol && in_valid;
            eol2 <= eol1;
            eol3 <= eol2;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            pix1 <= in_pix;
            sh2  <= sh_c;
            ofs2 <= s1_coeff.ofs;
            res3 <= clamp_c;
        end
    end

    assign out_valid = v3;
    assign out_pix   = res3;
    assign out_sof   = sof3;
    assign out_eol   = eol3;

endmodule

// File: rtl/pixel_nuc.sv
module pixel_nuc
    import pixel_nuc_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int ROWS  = 4,
    parameter int SET_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic               pix_sof,
    input  logic               pix_eol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_data,
    output logic               out_sof,
    output logic               out_eol,
    input  logic               ld_start,
    input  logic [SET_W-1:0]   ld_set,
    input  logic               ld_valid,
    output logic               ld_ready,
    input  logic [GAIN_W-1:0]  ld_gain,
    input  logic [OFS_W-1:0]   ld_offset,
    output logic               active_bank,
    output logic [SET_W-1:0]   active_set,
    output logic               swap_pending
);

    localparam int DEPTH = COLS * ROWS;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic          adv;
    logic          accept;
    logic          frame_go;
    logic          swap_now;
    logic          ld_we;
    logic [AW-1:0] ld_waddr;
    logic          wr_bank;
    logic          read_bank;
    logic          sel_q;
    logic [AW-1:0] idx_q;
    logic [AW-1:0] rd_idx;
    coeff_t        wr_word;
    coeff_t        rd_word [NUM_BANKS];
    coeff_t        s1_coeff;

    // Global stall: pipeline moves whenever the output slot can drain
    assign adv       = out_ready || !out_valid;
    assign pix_ready = adv;
    assign accept    = pix_valid && adv;
    assign frame_go  = accept && pix_sof;

    // Raster index of the pixel being accepted
    assign rd_idx = pix_sof ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= (rd_idx == LAST_IDX) ? '0 : rd_idx + AW'(1);
        end
    end

    // The swapping pixel already reads from the incoming bank
    assign read_bank = active_bank ^ swap_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (adv) begin
            sel_q <= read_bank;
        end
    end

    assign wr_word.gain = ld_gain;
    assign wr_word.ofs  = ld_offset;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pixel_nuc_bank #(
            .DEPTH (DEPTH),
            .AW    (AW)
        ) u_bank (
            .clk   (clk),
            .we    (ld_we && (wr_bank == 1'(b))),
            .waddr (ld_waddr),
            .wdata (wr_word),
            .re    (adv),
            .raddr (rd_idx),
            .rdata (rd_word[b])
        );
    end

    assign s1_coeff = sel_q ? rd_word[1] : rd_word[0];

    pixel_nuc_loader #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .SET_W (SET_W)
    ) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ld_start),
        .set_id      (ld_set),
        .word_valid  (ld_valid),
        .frame_go    (frame_go),
        .word_ready  (ld_ready),
        .we          (ld_we),
        .waddr       (ld_waddr),
        .wr_bank     (wr_bank),
        .swap_now    (swap_now),
        .active_bank (active_bank),
        .active_set  (active_set),
        .pending     (swap_pending)
    );

    pixel_nuc_math u_math (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .in_valid  (accept),
        .in_pix    (pix_data),
        .in_sof    (pix_sof),
        .in_eol    (pix_eol),
        .s1_coeff  (s1_coeff),
        .out_valid (out_valid),
        .out_pix   (out_data),
        .out_sof   (out_sof),
        .out_eol   (out_eol)
    );

endmodule

// File: rtl/pixel_nuc_checker.sv
module pixel_nuc_checker
    import pixel_nuc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             pix_sof,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             ld_ready,
    input logic             swap_pending,
    input logic             active_bank
);

    // R7: the bank pointer moves only after an accepted frame start with a finished load
    a_r7_swap_at_sof: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_bank) |->
            $past(pix_valid && pix_ready && pix_sof && swap_pending && !ld_ready));

    // R7: the pending flag drops only together with a bank swap
    a_r7_pending_clears_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swap_pending) |-> !$stable(active_bank));

    // R6: loader words are taken only while a load is pending
    a_r6_ready_means_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> swap_pending);

    // R5: a stalled output holds its value
    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5: no input accepted while the output is stalled
    a_r5_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !pix_ready);

endmodule

bind pixel_nuc pixel_nuc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_ready    (pix_ready),
    .pix_sof      (pix_sof),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .ld_ready     (ld_ready),
    .swap_pending (swap_pending),
    .active_bank  (active_bank)
);

// File: tb/pixel_nuc_bench.sv
`timescale 1ns/1ps
module pixel_nuc_bench;

    localparam int COLS  = 4;
    localparam int ROWS  = 2;
    localparam int NPIX  = COLS * ROWS;
    localparam int SET_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_valid = 1'b0;
    logic             pix_ready;
    logic [13:0]      pix_data = '0;
    logic             pix_sof = 1'b0;
    logic             pix_eol = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [13:0]      out_data;
    logic             out_sof;
    logic             out_eol;
    logic             ld_start = 1'b0;
    logic [SET_W-1:0] ld_set = '0;
    logic             ld_valid = 1'b0;
    logic             ld_ready;
    logic [15:0]      ld_gain = '0;
    logic [15:0]      ld_offset = '0;
    logic             active_bank;
    logic [SET_W-1:0] active_set;
    logic             swap_pending;

    always #10 clk = ~clk;

    pixel_nuc #(.COLS(COLS), .ROWS(ROWS), .SET_W(SET_W)) u_pixel_nuc (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .pix_sof(pix_sof), .pix_eol(pix_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol),
        .ld_start(ld_start), .ld_set(ld_set), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_gain(ld_gain), .ld_offset(ld_offset),
        .active_bank(active_bank), .active_set(active_set), .swap_pending(swap_pending)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int waits  = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int d;
        bit s;
        bit e;
        int t;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Coefficient tables: table 0 hits the saturation corners, table 1 is computed
    function automatic int gain_of(input int tbl, input int i);
        if (tbl == 0) begin
            case (i)
                0: return 4096;  1: return 0;     2: return 65535; 3: return 2048;
                4: return 8192;  5: return 4096;  6: return 12345; default: return 1;
            endcase
        end
        return (i * 7919 + 300) % 65536;
    endfunction

    function automatic int ofs_of(input int tbl, input int i);
        if (tbl == 0) begin
            case (i)
                0: return 0;     1: return 100;   2: return -32768; 3: return 32767;
                4: return -5;    5: return -200;  6: return 0;      default: return 7;
            endcase
        end
        return i * 3001 - 12000;
    endfunction

    function automatic int pix_of(input int f, input int i);
        if (f == 1) return 0;
        if (f == 2) return 16383;
        return (f * 4099 + i * 2741 + 77) % 16384;
    endfunction

    // R1 arithmetic model
    function automatic int model(input int p, input int g, input int o);
        longint s;
        s = ((longint'(p) * longint'(g)) >>> 12) + longint'(o);
        if (s < 0) return 0;
        if (s > 16383) return 16383;
        return int'(s);
    endfunction

    // Back-pressure pattern
    always @(negedge clk) begin
        out_ready <= bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Output monitor
    bit prev_stall = 1'b0;
    int prev_data  = 0;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (prev_stall) begin
                    chk("R5 output held valid under stall", int'(out_valid), 1);
                    chk("R5 output data held under stall", int'(out_data), prev_data);
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = int'(out_data);
                if (prev_stall) chk("R5 pix_ready low under stall", int'(pix_ready), 0);
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        chk("R3 unexpected output pixel", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk("R1 corrected value", int'(out_data), e.d);
                        chk("R3 out_sof aligned", int'(out_sof), int'(e.s));
                        chk("R3 out_eol aligned", int'(out_eol), int'(e.e));
                        if (!bp_mode) chk("R3 latency of three edges", cyc, e.t);
                    end
                end
            end
        end
    end

    task automatic load_start(input int id);
        @(negedge clk);
        ld_start = 1'b1;
        ld_set   = SET_W'(id);
        @(negedge clk);
        ld_start = 1'b0;
    endtask

    task automatic load_words(input int tbl, input int first, input int count);
        for (int i = first; i < first + count; i++) begin
            @(negedge clk);
            ld_valid  = 1'b1;
            ld_gain   = 16'(gain_of(tbl, i));
            ld_offset = 16'(ofs_of(tbl, i));
            #1;
            while (!ld_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
    endtask

    task automatic run_frame(input int tbl, input int f, input int npix, input bit gaps);
        waits = 0;
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                pix_valid = 1'b0;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_data  = 14'(pix_of(f, i));
            pix_sof   = (i == 0);
            pix_eol   = ((i % COLS) == COLS - 1);
            #1;
            while (!pix_ready) begin
                waits++;
                @(negedge clk);
                #1;
            end
            q.push_back('{d: model(pix_of(f, i), gain_of(tbl, i), ofs_of(tbl, i)),
                          s: (i == 0), e: ((i % COLS) == COLS - 1), t: cyc + 3});
        end
        @(negedge clk);
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_eol   = 1'b0;
    endtask

    task automatic drain;
        for (int k = 0; k < 60 && q.size() != 0; k++) @(negedge clk);
        chk("R3 all accepted pixels delivered", q.size(), 0);
        @(negedge clk);
        #3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        chk("R10 out_valid after reset", int'(out_valid), 0);
        chk("R10 swap_pending after reset", int'(swap_pending), 0);
        chk("R10 ld_ready after reset", int'(ld_ready), 0);
        chk("R10 active_bank after reset", int'(active_bank), 0);
        chk("R10 active_set after reset", int'(active_set), 0);
        chk("R4 pix_ready after reset", int'(pix_ready), 1);

        // Load table 0 as set 5
        load_start(5);
        #1;
        chk("R6 pending after start", int'(swap_pending), 1);
        chk("R6 ld_ready after start", int'(ld_ready), 1);
        load_words(0, 0, NPIX);
        chk("R6 ld_ready low after all words", int'(ld_ready), 0);
        chk("R7 pending until frame start", int'(swap_pending), 1);
        chk("R7 no swap before frame start", int'(active_bank), 0);

        // First frame swaps in table 0 on its first pixel
        run_frame(0, 0, NPIX, 1'b0);
        chk("R4 no input stall with out_ready high", waits, 0);
        drain();
        chk("R7 active_bank after swap", int'(active_bank), 1);
        chk("R7 active_set after swap", int'(active_set), 5);
        chk("R7 pending cleared", int'(swap_pending), 0);

        // Sweep pixel patterns, including the range ends
        for (int f = 1; f < 8; f++) begin
            run_frame(0, f, NPIX, f[0]);
            if (!f[0]) chk("R4 no input stall with out_ready high", waits, 0);
        end
        drain();

        // R2: truncated frame, then a new frame restarts at index 0
        run_frame(0, 9, 3, 1'b0);
        run_frame(0, 10, NPIX, 1'b0);
        drain();

        // R5: back-pressure during a frame
        bp_mode = 1'b1;
        run_frame(0, 11, NPIX, 1'b0);
        run_frame(0, 12, NPIX, 1'b0);
        for (int k = 0; k < 60 && q.size() != 0; k++) @(negedge clk);
        bp_mode = 1'b0;
        drain();

        // R8: frame starts while the next load is half written
        load_start(2);
        load_words(1, 0, NPIX / 2);
        run_frame(0, 13, NPIX, 1'b0);
        drain();
        chk("R8 bank unchanged mid-load", int'(active_bank), 1);
        chk("R8 set unchanged mid-load", int'(active_set), 5);
        chk("R8 pending stays high mid-load", int'(swap_pending), 1);

        // R9: second start while filling is ignored
        load_start(6);
        load_words(1, NPIX / 2, NPIX - NPIX / 2);
        chk("R9 ld_ready low after remaining words", int'(ld_ready), 0);
        chk("R9 pending still set", int'(swap_pending), 1);
        load_start(7);
        #1;
        chk("R9 start while armed leaves ld_ready low", int'(ld_ready), 0);

        // Swap in table 1
        run_frame(1, 14, NPIX, 1'b0);
        drain();
        chk("R7 active_bank after second swap", int'(active_bank), 0);
        chk("R9 active_set keeps first identifier", int'(active_set), 2);
        chk("R7 pending cleared after second swap", int'(swap_pending), 0);
        for (int f = 1; f < 6; f++) run_frame(1, f + 20 - ((f < 3) ? 20 : 0), NPIX, 1'b0);
        drain();
        chk("R6 ld_ready low when idle", int'(ld_ready), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule